// File: doc/BRIEF.md
# Four-channel DMA sequencer with global abort flags

The block is the control core of a four-channel DMA engine. Each channel keeps a source address, a destination address, a transfer count and a small control word. One global word holds the master enable and two sticky abort flags: one for an address fault and one for a non-maskable interrupt. Software sets all of these through a simple register write port. A combinational read port lets software see where every channel stands.

Channels that are ready are served by fixed priority. The block issues one word transfer at a time on a request/acknowledge bus-master interface. On each acknowledge it advances the channel's addresses and decrements its count. When the count runs out, it sets the channel's end flag.

An NMI pulse or a bad address freezes every channel where it stands. The addresses and counts then show exactly where work stopped, and nothing moves until software clears the flag. Clearing the master enable is gentler: the bus cycle in flight finishes, and then no new cycle starts.

Top module: `dma4_core`

## Requirements
- R1: A channel issues requests only while its enable bit (control bit 0) and the global master enable (global bit 0) are both 1. Either may be set first.
- R2: A pulse on `nmi_i` sets the global NMI flag (global bit 2) at the next clock edge, whether or not any channel is active.
- R3: While the NMI flag is 1, `req_o` is 0 from the cycle after the pulse. A cycle in flight is abandoned without an acknowledge, and every count keeps its value: the initial value if nothing had run, otherwise the remaining count.
- R4: After an abort, each channel's source and destination registers read back the addresses of the next transfer it would have made.
- R5: If the winning channel has a source, or (in dual mode) a destination, whose top byte is 0xFF (the control region), the global address-error flag (global bit 1) is set. No request is issued, and every channel stays halted.
- R6: In single-address mode (control bit 4), a source whose top byte is 0xFE (the peripheral region) is an address error. The destination is ignored.
- R7: Writing 0 to the master enable while `req_o` is high leaves the request up until `ack_i`. That transfer completes normally, and no further request follows.
- R8: On the acknowledge that takes a count from 1 to 0, the channel's end flag (control bit 1) is set and the channel stops requesting. A channel whose count is 0 never requests.
- R9: Among ready channels the lowest index wins. Only one request is outstanding at a time.
- R10: Both global flags are sticky. Writing 0 to a flag clears it and writing 1 has no effect. No request starts while either flag is 1.
- R11: On each acknowledge, the source advances by 4 when control bit 2 is 1 and the destination advances by 4 when control bit 3 is 1; otherwise each stays fixed.
- R12: While `req_o` is high and no acknowledge or NMI occurs, `req_o`, `chan_o` and both address outputs hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_chan_i | input | 2 | Channel selected for the write |
| wr_sel_i | input | 3 | Register selected for the write: 0 src, 1 dst, 2 count, 3 control, 4 global |
| wr_data_i | input | 32 | Write data |
| rd_chan_i | input | 2 | Channel selected for the read |
| rd_sel_i | input | 3 | Register selected for the read, same coding as the write |
| rd_data_o | output | 32 | Read data, combinational |
| nmi_i | input | 1 | Non-maskable interrupt pulse |
| req_o | output | 1 | Bus transfer request |
| ack_i | input | 1 | Transfer acknowledge, valid while `req_o` is high |
| chan_o | output | 2 | Channel that owns the current request |
| src_addr_o | output | 32 | Source address of the current request |
| dst_addr_o | output | 32 | Destination address of the current request |
| single_o | output | 1 | Current request is a single-address transfer |

## Verification
A stuck or misrouted owner register shows up in the first request: `chan_o` or the address outputs are wrong in the cycle that `req_o` rises. A wrong count or address step stays hidden until readback, or until the request that follows an acknowledge. Flag state that fails to stick or fails to clear shows up within one cycle, as `req_o` being high when it must not be, or a request that never arrives. The bench therefore compares request addresses at every acknowledge and reads back counts, addresses and flags after each abort.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_GLOB = 3'd4;

  typedef struct packed {
    logic single;
    logic dst_inc;
    logic src_inc;
    logic done;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_src_i,
  input  logic          wr_dst_i,
  input  logic          wr_cnt_i,
  input  logic          wr_ctrl_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output ctrl_t         ctrl_o,
  output logic          ready_o
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      ctrl_o <= '0;
    end else if (step_i) begin
      cnt_o <= cnt_o - CW'(1);
      if (ctrl_o.src_inc) src_o <= src_o + STEP;
      if (ctrl_o.dst_inc) dst_o <= dst_o + STEP;
      if (cnt_o == CW'(1)) ctrl_o.done <= 1'b1;
    end else begin
      if (wr_src_i)  src_o  <= wr_data_i;
      if (wr_dst_i)  dst_o  <= wr_data_i;
      if (wr_cnt_i)  cnt_o  <= wr_data_i[CW-1:0];
      if (wr_ctrl_i) ctrl_o <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end
  end

  assign ready_o = ctrl_o.en && !ctrl_o.done && (cnt_o != '0);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N   = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] gnt_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma4_addr_chk.sv
module dma4_addr_chk #(
  parameter int            AW       = 32,
  parameter int            TAG_W    = 8,
  parameter logic [TAG_W-1:0] CTRL_TAG = 8'hFF,
  parameter logic [TAG_W-1:0] PERI_TAG = 8'hFE
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          single_i,
  output logic          bad_o
);
  logic [TAG_W-1:0] src_tag, dst_tag;
  assign src_tag = src_i[AW-1 -: TAG_W];
  assign dst_tag = dst_i[AW-1 -: TAG_W];

  always_comb begin
    bad_o = (src_tag == CTRL_TAG);
    if (single_i) bad_o = bad_o || (src_tag == PERI_TAG);
    else          bad_o = bad_o || (dst_tag == CTRL_TAG);
  end
endmodule

// File: rtl/dma4_core.sv
module dma4_core
  import dma4_pkg::*;
#(
  parameter int            NCH        = 4,
  parameter int            AW         = 32,
  parameter int            CW         = 16,
  parameter int            WORD_BYTES = 4,
  parameter int            TAG_W      = 8,
  parameter logic [TAG_W-1:0] CTRL_TAG = 8'hFF,
  parameter logic [TAG_W-1:0] PERI_TAG = 8'hFE,
  localparam int           CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [CHW-1:0] wr_chan_i,
  input  logic [2:0]     wr_sel_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic [CHW-1:0] rd_chan_i,
  input  logic [2:0]     rd_sel_i,
  output logic [AW-1:0]  rd_data_o,
  input  logic           nmi_i,
  output logic           req_o,
  input  logic           ack_i,
  output logic [CHW-1:0] chan_o,
  output logic [AW-1:0]  src_addr_o,
  output logic [AW-1:0]  dst_addr_o,
  output logic           single_o
);
  logic [AW-1:0] src_a [NCH];
  logic [AW-1:0] dst_a [NCH];
  logic [CW-1:0] cnt_a [NCH];
  ctrl_t         ctl_a [NCH];
  logic [NCH-1:0] ready;

  logic           master_q, ae_q, nmi_q, busy_q;
  logic [CHW-1:0] cur_q;
  logic [CHW-1:0] gnt;
  logic           any_ready, launch_ok, addr_bad, ack_ok, glob_wr;

  assign glob_wr = wr_en_i && (wr_sel_i == SEL_GLOB);
  assign ack_ok  = req_o && ack_i;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic sel_ch;
    assign sel_ch = wr_en_i && (wr_chan_i == CHW'(g));
    dma4_chan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_src_i (sel_ch && (wr_sel_i == SEL_SRC)),
      .wr_dst_i (sel_ch && (wr_sel_i == SEL_DST)),
      .wr_cnt_i (sel_ch && (wr_sel_i == SEL_CNT)),
      .wr_ctrl_i(sel_ch && (wr_sel_i == SEL_CTRL)),
      .wr_data_i(wr_data_i),
      .step_i   (ack_ok && (cur_q == CHW'(g))),
      .src_o    (src_a[g]),
      .dst_o    (dst_a[g]),
      .cnt_o    (cnt_a[g]),
      .ctrl_o   (ctl_a[g]),
      .ready_o  (ready[g])
    );
  end

  dma4_arb #(.N(NCH)) u_arb (
    .req_i(ready),
    .gnt_o(gnt),
    .any_o(any_ready)
  );

  dma4_addr_chk #(.AW(AW), .TAG_W(TAG_W), .CTRL_TAG(CTRL_TAG), .PERI_TAG(PERI_TAG)) u_chk_addr (
    .src_i   (src_a[gnt]),
    .dst_i   (dst_a[gnt]),
    .single_i(ctl_a[gnt].single),
    .bad_o   (addr_bad)
  );

  assign launch_ok = !busy_q && master_q && !ae_q && !nmi_q && any_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      ae_q     <= 1'b0;
      nmi_q    <= 1'b0;
      busy_q   <= 1'b0;
      cur_q    <= '0;
    end else begin
      if (glob_wr) master_q <= wr_data_i[0];

      if (nmi_i)        nmi_q <= 1'b1;
      else if (glob_wr) nmi_q <= nmi_q & wr_data_i[2];

      if (launch_ok && addr_bad) ae_q <= 1'b1;
      else if (glob_wr)          ae_q <= ae_q & wr_data_i[1];

      // NMI abandons the cycle in flight; master clear waits for ack
      if (busy_q) begin
        if (nmi_q || ack_i) busy_q <= 1'b0;
      end else if (launch_ok && !addr_bad) begin
        busy_q <= 1'b1;
        cur_q  <= gnt;
      end
    end
  end

  assign req_o      = busy_q && !nmi_q;
  assign chan_o     = cur_q;
  assign src_addr_o = src_a[cur_q];
  assign dst_addr_o = dst_a[cur_q];
  assign single_o   = ctl_a[cur_q].single;

  always_comb begin
    unique case (rd_sel_i)
      SEL_SRC:  rd_data_o = src_a[rd_chan_i];
      SEL_DST:  rd_data_o = dst_a[rd_chan_i];
      SEL_CNT:  rd_data_o = AW'(cnt_a[rd_chan_i]);
      SEL_CTRL: rd_data_o = AW'(ctl_a[rd_chan_i]);
      SEL_GLOB: rd_data_o = AW'({nmi_q, ae_q, master_q});
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/dma4_core_chk.sv
module dma4_core_chk #(
  parameter int CHW = 2,
  parameter int AW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_o,
  input logic           ack_i,
  input logic           nmi_i,
  input logic [CHW-1:0] chan_o,
  input logic [AW-1:0]  src_addr_o,
  input logic [AW-1:0]  dst_addr_o,
  input logic           nmi_flag,
  input logic           ae_flag,
  input logic           master
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !nmi_i) |=> (req_o && $stable(chan_o) && $stable(src_addr_o) && $stable(dst_addr_o))); // R12
  AST_NMI_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> nmi_flag); // R2
  AST_NMI_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_flag |-> !req_o); // R3
  AST_LAUNCH_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(master && !ae_flag && !nmi_flag)); // R1
  AST_AE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ae_flag && !req_o) |=> !req_o); // R5
endmodule

bind dma4_core dma4_core_chk #(.CHW(CHW), .AW(AW)) u_core_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_o     (req_o),
  .ack_i     (ack_i),
  .nmi_i     (nmi_i),
  .chan_o    (chan_o),
  .src_addr_o(src_addr_o),
  .dst_addr_o(dst_addr_o),
  .nmi_flag  (nmi_q),
  .ae_flag   (ae_q),
  .master    (master_q)
);

// File: tb/dma4_core_bench.sv
`timescale 1ns/1ps
module dma4_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_chan_i = '0;
  logic [2:0]  wr_sel_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_chan_i = '0;
  logic [2:0]  rd_sel_i = '0;
  logic [31:0] rd_data_o;
  logic        nmi_i = 1'b0;
  logic        req_o;
  logic        ack_i = 1'b0;
  logic [1:0]  chan_o;
  logic [31:0] src_addr_o, dst_addr_o;
  logic        single_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  dma4_core u_dma4_core (
    .clk_i, .rst_ni, .wr_en_i, .wr_chan_i, .wr_sel_i, .wr_data_i,
    .rd_chan_i, .rd_sel_i, .rd_data_o, .nmi_i, .req_o, .ack_i,
    .chan_o, .src_addr_o, .dst_addr_o, .single_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0; nmi_i = 1'b0; ack_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_chan_i = ch; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] ch, input logic [2:0] sel, output logic [31:0] d);
    rd_chan_i = ch; rd_sel_i = sel;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic wait_req(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 40 && !ok; i++) begin
      @(negedge clk_i);
      if (req_o) ok = 1'b1;
    end
  endtask

  task automatic ack_now();
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic no_req(input int n, input string tag);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (req_o) seen = 1'b1;
    end
    chk(tag, {31'd0, seen}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 reset req", {31'd0, req_o}, 32'd0);
    rd(0, 3'd4, d); chk("R10 reset global", d, 32'd0);
    rd(2, 3'd2, d); chk("R8 reset count", d, 32'd0);
  endtask

  task automatic t_basic();
    logic ok; logic [31:0] d;
    do_reset();
    wr(1, 3'd0, 32'h0000_1000);
    wr(1, 3'd1, 32'h0000_2000);
    wr(1, 3'd2, 32'd3);
    wr(1, 3'd3, 32'h05);
    no_req(8, "R1 channel enable alone");
    wr(0, 3'd4, 32'h1);
    for (int i = 0; i < 3; i++) begin
      wait_req(ok);
      chk("R1 request after both enables", {31'd0, ok}, 32'd1);
      chk("R9 owner", {30'd0, chan_o}, 32'd1);
      chk("R11 src step", src_addr_o, 32'h1000 + 32'(4 * i));
      chk("R11 dst fixed", dst_addr_o, 32'h2000);
      @(negedge clk_i);
      chk("R12 held without ack", {31'd0, req_o}, 32'd1);
      ack_now();
    end
    no_req(10, "R8 stops at zero");
    rd(1, 3'd2, d); chk("R8 count zero", d, 32'd0);
    rd(1, 3'd3, d); chk("R8 end flag", d & 32'h2, 32'h2);
    rd(1, 3'd0, d); chk("R11 final src", d, 32'h100C);
  endtask

  task automatic t_order_and_zero();
    logic ok;
    do_reset();
    wr(0, 3'd4, 32'h1);
    wr(3, 3'd3, 32'h01);
    no_req(8, "R8 zero count never requests");
    wr(3, 3'd2, 32'd1);
    wait_req(ok);
    chk("R1 master first then channel", {31'd0, ok}, 32'd1);
    ack_now();
  endtask

  task automatic t_priority();
    logic ok;
    do_reset();
    wr(2, 3'd0, 32'h300); wr(2, 3'd1, 32'h400); wr(2, 3'd2, 32'd1); wr(2, 3'd3, 32'h01);
    wr(0, 3'd0, 32'h100); wr(0, 3'd1, 32'h200); wr(0, 3'd2, 32'd1); wr(0, 3'd3, 32'h01);
    wr(0, 3'd4, 32'h1);
    wait_req(ok);
    chk("R9 lowest first", {30'd0, chan_o}, 32'd0);
    ack_now();
    chk("R9 single outstanding", {31'd0, req_o}, 32'd0);
    wait_req(ok);
    chk("R9 next channel", {30'd0, chan_o}, 32'd2);
    ack_now();
  endtask

  task automatic t_nmi_mid();
    logic ok; logic [31:0] d;
    do_reset();
    wr(0, 3'd0, 32'h100); wr(0, 3'd1, 32'h200); wr(0, 3'd2, 32'd5); wr(0, 3'd3, 32'h0D);
    wr(1, 3'd2, 32'd7); wr(1, 3'd3, 32'h01);
    wr(0, 3'd4, 32'h1);
    for (int i = 0; i < 2; i++) begin
      wait_req(ok);
      ack_now();
    end
    wait_req(ok);
    nmi_i = 1'b1;
    @(negedge clk_i);
    nmi_i = 1'b0;
    chk("R3 request dropped", {31'd0, req_o}, 32'd0);
    no_req(6, "R3 frozen");
    rd(0, 3'd2, d); chk("R3 remaining count", d, 32'd3);
    rd(1, 3'd2, d); chk("R3 untouched count", d, 32'd7);
    rd(0, 3'd0, d); chk("R4 next src", d, 32'h108);
    rd(0, 3'd1, d); chk("R4 next dst", d, 32'h208);
    rd(0, 3'd4, d); chk("R2 nmi flag", d, 32'h5);
    wr(0, 3'd4, 32'h7);
    rd(0, 3'd4, d); chk("R10 write one keeps flag", d, 32'h5);
    no_req(4, "R10 no start while flagged");
    wr(0, 3'd4, 32'h1);
    wait_req(ok);
    chk("R10 resume after clear", {31'd0, ok}, 32'd1);
    chk("R4 resumes at next src", src_addr_o, 32'h108);
    ack_now();
  endtask

  task automatic t_nmi_idle();
    logic [31:0] d;
    do_reset();
    wr(2, 3'd2, 32'd9);
    @(negedge clk_i); nmi_i = 1'b1;
    @(negedge clk_i); nmi_i = 1'b0;
    rd(0, 3'd4, d); chk("R2 flag while idle", d, 32'h4);
    wr(2, 3'd3, 32'h01);
    wr(0, 3'd4, 32'h5);
    no_req(6, "R3 blocked before start");
    rd(2, 3'd2, d); chk("R3 initial count kept", d, 32'd9);
    wr(0, 3'd4, 32'h3);
    rd(0, 3'd4, d); chk("R10 write zero clears, one does not set", d, 32'h1);
  endtask

  task automatic t_addr_err();
    logic ok; logic [31:0] d;
    do_reset();
    wr(0, 3'd0, 32'hFF00_0010); wr(0, 3'd1, 32'h300); wr(0, 3'd2, 32'd2); wr(0, 3'd3, 32'h05);
    wr(1, 3'd0, 32'h500); wr(1, 3'd1, 32'h600); wr(1, 3'd2, 32'd2); wr(1, 3'd3, 32'h05);
    wr(0, 3'd4, 32'h1);
    no_req(10, "R5 no request on bad address");
    rd(0, 3'd4, d); chk("R5 address error flag", d, 32'h3);
    rd(1, 3'd2, d); chk("R5 other channel halted", d, 32'd2);
    wr(0, 3'd0, 32'h400);
    wr(0, 3'd4, 32'h3);
    rd(0, 3'd4, d); chk("R10 sticky address flag", d, 32'h3);
    wr(0, 3'd4, 32'h1);
    wait_req(ok);
    chk("R10 restart after clear", {31'd0, ok}, 32'd1);
    chk("R5 fixed channel runs", src_addr_o, 32'h400);
    ack_now();
  endtask

  task automatic t_single();
    logic ok; logic [31:0] d;
    do_reset();
    wr(2, 3'd0, 32'hFE00_0000); wr(2, 3'd1, 32'h700); wr(2, 3'd2, 32'd1); wr(2, 3'd3, 32'h11);
    wr(0, 3'd4, 32'h1);
    no_req(8, "R6 peripheral source rejected");
    rd(0, 3'd4, d); chk("R6 address error flag", d, 32'h3);
    wr(2, 3'd0, 32'h0800_0000);
    wr(2, 3'd1, 32'hFF00_0000);
    wr(0, 3'd4, 32'h1);
    wait_req(ok);
    chk("R6 destination ignored in single mode", {31'd0, ok}, 32'd1);
    chk("R6 single flag", {31'd0, single_o}, 32'd1);
    ack_now();
  endtask

  task automatic t_master_clear();
    logic ok; logic [31:0] d;
    do_reset();
    wr(0, 3'd0, 32'h100); wr(0, 3'd1, 32'h200); wr(0, 3'd2, 32'd4); wr(0, 3'd3, 32'h0D);
    wr(0, 3'd4, 32'h1);
    wait_req(ok);
    wr(0, 3'd4, 32'h0);
    chk("R7 request survives master clear", {31'd0, req_o}, 32'd1);
    ack_now();
    no_req(10, "R7 no new request");
    rd(0, 3'd2, d); chk("R7 cycle completed", d, 32'd3);
    rd(0, 3'd0, d); chk("R7 src advanced", d, 32'h104);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_order_and_zero();
    t_priority();
    t_nmi_mid();
    t_nmi_idle();
    t_addr_err();
    t_single();
    t_master_clear();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule